// File: doc/BRIEF.md
# NAND Controller Control and Status Registers

This block is the software-visible register file of a NAND flash controller. It sits behind a simple 32-bit register bus made of a word address, a write strobe, a read strobe, byte enables, write data and read data. It holds the controller's configuration and reports the controller's state. Two registers set up the flash interface: the interface configuration and the access timing. Both are guarded by an unlock key. After the 16-bit key 0xA25E is written to the lock register, exactly one write to either guarded register is accepted. The guard then closes again by itself.

The datapath reports events as one-cycle pulses. The block latches them into an interrupt status register, which is cleared when it is read. The block also ANDs that register with a mask to drive a level interrupt. A live status register shows the datapath's present ready and ECC state. A reset code written to the command register produces a one-cycle controller-reset pulse. A chip-enable mode bit tells the pin sequencer whether it drives chip enable itself.

Word map (reg_addr): 0 command, 1 lock, 2 interface configuration, 3 timing, 4 interrupt mask, 5 interrupt status, 6 live status, 7 chip-enable mode.

Top module: `nand_ctl_regs`

## Requirements
- R1: The guarded registers open for one write only when a write to word 1 has both reg_be[1] and reg_be[0] set and reg_wdata[15:0] equal to 0xA25E. Reading word 1 returns 1 in bit 0 while they are open, and 0 otherwise.
- R2: A write to word 2 or word 3 while the guard is closed is ignored, and the stored value does not change.
- R3: Any write to word 2 or word 3 closes the guard again. So does any write to word 1 that is not a full key write.
- R4: Field positions are as follows. Word 2 bits 3:0 hold {write-protect enable, large block, long address, 16-bit bus} and appear on cfg_out. Word 3 holds TIM_W bits, written per byte lane, and appears on timing_out. Word 4 bits 5:0 hold the interrupt mask. Word 7 bit 0 drives ce_normal. All unused bits read as 0.
- R5: Word 5 latches event pulses at these bit positions: 5 NAND ready, 4 controller ready, 3 decode failure, 2 decode error, 1 ECC ready, 0 write-protect fault. A read of word 5 returns the latched bits and clears them at the same clock edge. Writes to word 5 have no effect.
- R6: irq is high exactly while some bit is set in both the interrupt status and the mask.
- R7: An event that arrives in the same cycle as a clearing read of word 5 stays latched after that read.
- R8: Word 6 reads the live inputs with bit 0 NAND ready, bit 1 controller ready, bit 2 ECC ready, bit 3 errors detected, bits 5:4 corrected count minus one, and bit 6 decoder failure.
- R9: A write of 0xFF to word 0 with reg_be[0] set makes ctl_reset high for the single cycle after that write. Any other value does nothing.
- R10: After reset, every stored register is 0, the guard is closed, and irq and ctl_reset are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 3 | Word address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (clears interrupt status on word 5) |
| reg_be | input | 4 | Byte enables |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| ev_wp_fault | input | 1 | Write-protect fault pulse |
| ev_ecc_rdy | input | 1 | ECC ready pulse |
| ev_dec_err | input | 1 | Decode error pulse |
| ev_dec_fail | input | 1 | Decode failure pulse |
| ev_ctrl_rdy | input | 1 | Controller ready pulse |
| ev_nand_rdy | input | 1 | NAND ready pulse |
| st_nand_rdy | input | 1 | Live NAND ready |
| st_ctrl_rdy | input | 1 | Live controller ready |
| st_ecc_rdy | input | 1 | Live ECC ready |
| st_err_det | input | 1 | Live errors detected |
| st_err_cnt | input | 2 | Live corrected-error count minus one |
| st_dec_fail | input | 1 | Live decoder failure |
| cfg_out | output | 4 | Interface configuration |
| timing_out | output | TIM_W | Timing register |
| ce_normal | output | 1 | Controller drives chip enable |
| ctl_reset | output | 1 | One-cycle controller reset pulse |
| irq | output | 1 | Level interrupt |

## Verification
The bench goes after the guard's one-shot behaviour in several forms:
- a second write after the key, which a guard that stays open would accept;
- a wrong lock value between the key and the write;
- a key sent with only the low byte strobe, which a guard that checks no strobes would take as a key.

It also issues a clearing read of the interrupt status in the same cycle as a new event. A design that clears without re-merging the incoming events would lose that event. Masked-off events, writes to the read-only words, and near-miss command codes are all checked so that none of them leaks onto irq, the stored state or ctl_reset.

// File: rtl/nand_ctl_regs.sv
`timescale 1ns/1ps
module nand_ctl_regs #(
  parameter int          TIM_W      = 27,
  parameter logic [15:0] UNLOCK_KEY = 16'hA25E
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       reg_addr,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [3:0]       reg_be,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             ev_wp_fault,
  input  logic             ev_ecc_rdy,
  input  logic             ev_dec_err,
  input  logic             ev_dec_fail,
  input  logic             ev_ctrl_rdy,
  input  logic             ev_nand_rdy,
  input  logic             st_nand_rdy,
  input  logic             st_ctrl_rdy,
  input  logic             st_ecc_rdy,
  input  logic             st_err_det,
  input  logic [1:0]       st_err_cnt,
  input  logic             st_dec_fail,
  output logic [3:0]       cfg_out,
  output logic [TIM_W-1:0] timing_out,
  output logic             ce_normal,
  output logic             ctl_reset,
  output logic             irq
);
  localparam logic [2:0] A_CMD = 3'd0, A_LOCK = 3'd1, A_CFG = 3'd2, A_TIM = 3'd3,
                         A_MASK = 3'd4, A_STAT = 3'd5, A_LIVE = 3'd6, A_CEH = 3'd7;
  localparam int PAD_W = 32 - TIM_W;

  logic       unlocked;
  logic [5:0] mask_q, stat_q;
  logic [31:0] tim_wide, tim_merged;

  wire [5:0] ev = {ev_nand_rdy, ev_ctrl_rdy, ev_dec_fail, ev_dec_err, ev_ecc_rdy, ev_wp_fault};
  wire wr_lock  = reg_wr && reg_addr == A_LOCK;
  wire wr_cfg   = reg_wr && reg_addr == A_CFG;
  wire wr_tim   = reg_wr && reg_addr == A_TIM;
  wire key_hit  = wr_lock && reg_be[1] && reg_be[0] && reg_wdata[15:0] == UNLOCK_KEY;
  wire stat_clr = reg_rd && reg_addr == A_STAT;

  assign tim_wide = {{PAD_W{1'b0}}, timing_out};
  always_comb
    for (int b = 0; b < 4; b++)
      tim_merged[8*b +: 8] = reg_be[b] ? reg_wdata[8*b +: 8] : tim_wide[8*b +: 8];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      unlocked   <= 1'b0;
      cfg_out    <= '0;
      timing_out <= '0;
      mask_q     <= '0;
      stat_q     <= '0;
      ce_normal  <= 1'b0;
      ctl_reset  <= 1'b0;
    end else begin
      ctl_reset <= reg_wr && reg_addr == A_CMD && reg_be[0] && reg_wdata[7:0] == 8'hFF;
      if (wr_lock) unlocked <= key_hit;
      else if (wr_cfg || wr_tim) unlocked <= 1'b0;
      if (wr_cfg && unlocked && reg_be[0]) cfg_out <= reg_wdata[3:0];
      if (wr_tim && unlocked) timing_out <= tim_merged[TIM_W-1:0];
      if (reg_wr && reg_addr == A_MASK && reg_be[0]) mask_q <= reg_wdata[5:0];
      if (reg_wr && reg_addr == A_CEH && reg_be[0]) ce_normal <= reg_wdata[0];
      stat_q <= (stat_clr ? 6'd0 : stat_q) | ev;
    end
  end

  assign irq = |(stat_q & mask_q);

  always_comb begin
    unique case (reg_addr)
      A_LOCK:  reg_rdata = {31'd0, unlocked};
      A_CFG:   reg_rdata = {28'd0, cfg_out};
      A_TIM:   reg_rdata = tim_wide;
      A_MASK:  reg_rdata = {26'd0, mask_q};
      A_STAT:  reg_rdata = {26'd0, stat_q};
      A_LIVE:  reg_rdata = {25'd0, st_dec_fail, st_err_cnt, st_err_det, st_ecc_rdy, st_ctrl_rdy, st_nand_rdy};
      A_CEH:   reg_rdata = {31'd0, ce_normal};
      default: reg_rdata = 32'd0;
    endcase
  end
endmodule

module nand_ctl_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  reg_addr,
  input logic        reg_wr,
  input logic        reg_rd,
  input logic [3:0]  reg_be,
  input logic [31:0] reg_wdata,
  input logic [31:0] reg_rdata,
  input logic [5:0]  ev,
  input logic [5:0]  mask_q,
  input logic [5:0]  stat_q,
  input logic        unlocked,
  input logic [3:0]  cfg_out,
  input logic        st_nand_rdy,
  input logic        ctl_reset,
  input logic        irq
);
  p_unlock_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd2 && unlocked && reg_be[0]) |=> cfg_out == $past(reg_wdata[3:0]));
  p_locked_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd2 && !unlocked) |=> $stable(cfg_out));
  p_relock_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && (reg_addr == 3'd2 || reg_addr == 3'd3)) |=> !unlocked);
  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 3'd5 && ev == 6'd0) |=> stat_q == 6'd0);
  p_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((ev & mask_q) != 6'd0 && !(reg_wr && reg_addr == 3'd4)) |=> irq);
  p_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 3'd5) |=> stat_q == $past(ev));
  p_live_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 3'd6) |-> reg_rdata[0] == st_nand_rdy);
  p_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd0 && reg_be[0] && reg_wdata[7:0] == 8'hFF) |=> ctl_reset);
endmodule

bind nand_ctl_regs nand_ctl_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev(ev),
  .mask_q(mask_q), .stat_q(stat_q), .unlocked(unlocked), .cfg_out(cfg_out),
  .st_nand_rdy(st_nand_rdy), .ctl_reset(ctl_reset), .irq(irq)
);

// File: tb/sim_nand_ctl_regs.sv
`timescale 1ns/1ps
module sim_nand_ctl_regs;
  localparam int TIM_W = 27;
  localparam logic [15:0] KEY = 16'hA25E;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] reg_addr = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0] reg_be = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [5:0] evv = '0;
  logic [6:0] lv = '0;
  logic [3:0] cfg_out;
  logic [TIM_W-1:0] timing_out;
  logic ce_normal, ctl_reset, irq;

  int n_chk = 0, n_fail = 0;
  logic unlk = 0, m_ceh = 0, m_rst = 0;
  logic [3:0] m_cfg = 0;
  logic [31:0] m_tim = 0;
  logic [5:0] m_mask = 0, m_stat = 0;

  always #2.5 clk = ~clk;

  nand_ctl_regs #(.TIM_W(TIM_W), .UNLOCK_KEY(KEY)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ev_wp_fault(evv[0]), .ev_ecc_rdy(evv[1]), .ev_dec_err(evv[2]), .ev_dec_fail(evv[3]),
    .ev_ctrl_rdy(evv[4]), .ev_nand_rdy(evv[5]),
    .st_nand_rdy(lv[0]), .st_ctrl_rdy(lv[1]), .st_ecc_rdy(lv[2]), .st_err_det(lv[3]),
    .st_err_cnt(lv[5:4]), .st_dec_fail(lv[6]),
    .cfg_out(cfg_out), .timing_out(timing_out), .ce_normal(ce_normal),
    .ctl_reset(ctl_reset), .irq(irq));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(logic [2:0] a);
    case (a)
      3'd1: return {31'd0, unlk};
      3'd2: return {28'd0, m_cfg};
      3'd3: return m_tim;
      3'd4: return {26'd0, m_mask};
      3'd5: return {26'd0, m_stat};
      3'd6: return {25'd0, lv};
      3'd7: return {31'd0, m_ceh};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(logic [2:0] a);
    case (a)
      3'd1: return "R1"; 3'd2: return "R4"; 3'd3: return "R4"; 3'd4: return "R4";
      3'd5: return "R5"; 3'd6: return "R8"; 3'd7: return "R4"; default: return "R9";
    endcase
  endfunction

  task automatic step(bit wr, bit rd, logic [2:0] a, logic [3:0] be, logic [31:0] d,
                      logic [5:0] e, string tag);
    @(negedge clk);
    reg_wr = wr; reg_rd = rd; reg_addr = a; reg_be = be; reg_wdata = d; evv = e;
    #1;
    if (rd) chk(tag, reg_rdata, m_read(a));
    chk("R6 irq", {31'd0, irq}, {31'd0, |(m_stat & m_mask)});
    chk("R9 ctl_reset", {31'd0, ctl_reset}, {31'd0, m_rst});
    chk("R2 cfg_out", {28'd0, cfg_out}, {28'd0, m_cfg});
    chk("R4 timing_out", {5'd0, timing_out}, m_tim);
    chk("R4 ce_normal", {31'd0, ce_normal}, {31'd0, m_ceh});
    @(posedge clk);
    m_rst = wr && a == 3'd0 && be[0] && d[7:0] == 8'hFF;
    if (wr && a == 3'd2 && unlk && be[0]) m_cfg = d[3:0];
    if (wr && a == 3'd3 && unlk)
      for (int b = 0; b < 4; b++) if (be[b]) m_tim[8*b +: 8] = d[8*b +: 8];
    m_tim[31:TIM_W] = '0;
    if (wr && a == 3'd1) unlk = be[1] && be[0] && d[15:0] == KEY;
    else if (wr && (a == 3'd2 || a == 3'd3)) unlk = 1'b0;
    if (wr && a == 3'd4 && be[0]) m_mask = d[5:0];
    if (wr && a == 3'd7 && be[0]) m_ceh = d[0];
    m_stat = ((rd && a == 3'd5) ? 6'd0 : m_stat) | e;
  endtask

  task automatic rd_reg(logic [2:0] a, string tag);
    step(0, 1, a, 4'h0, 32'h0, 6'h0, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    for (int a = 0; a < 8; a++) rd_reg(3'(a), "R10 reset");
    // R2: guarded write without key
    step(1, 0, 3'd2, 4'hF, 32'h6, 6'h0, "R2");
    rd_reg(3'd2, "R2 locked cfg");
    // R1: key then write
    step(1, 0, 3'd1, 4'h3, {16'h0, KEY}, 6'h0, "R1");
    rd_reg(3'd1, "R1 open");
    step(1, 0, 3'd2, 4'h1, 32'h6, 6'h0, "R1");
    rd_reg(3'd2, "R1 cfg accepted");
    // R3: second write ignored
    step(1, 0, 3'd2, 4'h1, 32'hF, 6'h0, "R3");
    rd_reg(3'd2, "R3 relocked cfg");
    // R3: wrong lock value closes guard
    step(1, 0, 3'd1, 4'h3, {16'h0, KEY}, 6'h0, "R3");
    step(1, 0, 3'd1, 4'h3, 32'h1234, 6'h0, "R3");
    rd_reg(3'd1, "R3 closed");
    step(1, 0, 3'd3, 4'hF, 32'h55, 6'h0, "R2");
    rd_reg(3'd3, "R2 locked timing");
    // R1: key with one strobe is no key
    step(1, 0, 3'd1, 4'h1, {16'h0, KEY}, 6'h0, "R1");
    rd_reg(3'd1, "R1 partial strobe");
    // R4: timing width, mask, ceh
    step(1, 0, 3'd1, 4'h3, {16'h0, KEY}, 6'h0, "R4");
    step(1, 0, 3'd3, 4'hF, 32'hFFFF_FFFF, 6'h0, "R4");
    rd_reg(3'd3, "R4 timing width");
    step(1, 0, 3'd4, 4'hF, 32'hFFFF_FFFF, 6'h0, "R4");
    rd_reg(3'd4, "R4 mask width");
    step(1, 0, 3'd7, 4'h1, 32'h1, 6'h0, "R4");
    rd_reg(3'd7, "R4 ceh");
    step(1, 0, 3'd4, 4'h1, 32'h10, 6'h0, "R4");
    // R5/R6: latch, masked event, clear
    step(0, 0, 3'd0, 4'h0, 32'h0, 6'h20, "R6");
    step(1, 0, 3'd5, 4'hF, 32'h0, 6'h0, "R5 write ignored");
    rd_reg(3'd5, "R5 latched");
    step(0, 0, 3'd0, 4'h0, 32'h0, 6'h10, "R6");
    step(0, 0, 3'd0, 4'h0, 32'h0, 6'h0, "R6");
    rd_reg(3'd5, "R5 read");
    rd_reg(3'd5, "R5 cleared");
    // R7: event during clearing read
    step(0, 0, 3'd0, 4'h0, 32'h0, 6'h04, "R7");
    step(0, 1, 3'd5, 4'h0, 32'h0, 6'h11, "R7 read");
    rd_reg(3'd5, "R7 kept");
    // R8: live status
    lv = 7'h55; rd_reg(3'd6, "R8 live");
    lv = 7'h2A; rd_reg(3'd6, "R8 live");
    // R9: command codes
    step(1, 0, 3'd0, 4'h1, 32'hFE, 6'h0, "R9");
    step(1, 0, 3'd0, 4'hE, 32'hFF, 6'h0, "R9");
    step(1, 0, 3'd0, 4'h1, 32'hFF, 6'h0, "R9");
    rd_reg(3'd0, "R9 pulse");
    rd_reg(3'd0, "R9 pulse end");
    // mixed random
    for (int i = 0; i < 1500; i++) begin
      logic [2:0] a = 3'($urandom_range(0, 7));
      bit wr = ($urandom_range(0, 2) == 0);
      bit rd = !wr && ($urandom_range(0, 1) == 0);
      logic [31:0] d = $urandom;
      logic [5:0] e = ($urandom_range(0, 2) == 0) ? 6'($urandom) : 6'h0;
      logic [3:0] be = ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'hF;
      if ($urandom_range(0, 3) == 0) begin a = 3'd1; d[15:0] = KEY; end
      if ($urandom_range(0, 9) == 0) d[7:0] = 8'hFF;
      lv = 7'($urandom);
      step(wr, rd, a, be, d, e, tag_of(a));
    end
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule